// File: doc/BRIEF.md
# Burst Line Fill Bus Interface

This block sits between a cache and a single-master memory bus of the cyc/stb/ack kind. The cache hands it one request at a time: either a line fill, which brings back a whole four-word line as one bus cycle, or a single uncached word read. Words come back to the cache one by one, each tagged with its slot index inside the line. The strobe that closes the request is raised on the last word.

A line fill begins at the word the cache asked for, the critical word, and wraps around inside the aligned line. A mode input, sampled when a request is accepted, picks one of two bus handshakes. The registered handshake drops the strobe for one clock after every acknowledge and idles the bus for one clock after the last one. The pipelined handshake keeps the strobe up and moves the address on at every acknowledged clock, so a fast memory delivers one word per clock and a single read occupies only two clocks.

The block only reads. The write-enable output is held low.

Top module: `line_fill_biu`

## Requirements
- R1: After reset, cyc_o, stb_o, rsp_valid and rsp_done are low and req_ready is high.
- R2: A line fill (req_line = 1) returns exactly LINE_WORDS = 4 words. Each word is the bus data sampled on an acknowledged clock. rsp_done is high on the fourth word only.
- R3: A fill starts at the critical word given by req_addr[3:2] and steps the word index by one modulo 4 on each acknowledge. adr_o carries the request line's upper bits and zeros in bits [1:0]. rsp_offset equals the word index in adr_o[3:2] of the returned word.
- R4: Pipelined mode (mode_fast = 1) holds stb_o high across beats. Beat n (counting from 0) completes in clock n+1+W, where clock 0 is the accepting clock and W is the number of wait clocks on the first beat.
- R5: Registered mode (mode_fast = 0) completes beat n in clock 2n+1+W. stb_o is low in the clock after every acknowledge.
- R6: cyc_o stays high from the first strobe clock until the last acknowledge of a transaction, and drops in the clock after it.
- R7: A single read (req_line = 0) returns one word from the request's word address with rsp_done set. In pipelined mode req_ready is high again in the clock after that word.
- R8: In registered mode, the clock after the last acknowledge of any transaction has cyc_o low and req_ready low, and req_ready returns one clock later.
- R9: mode_fast, req_line, req_addr and req_valid are ignored while a transaction is in progress. The transaction continues unchanged, and no second one starts from them.
- R10: While the memory withholds ack_i, stb_o stays high and adr_o holds steady.
- R11: we_o is low at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Cache request present |
| req_line | input | 1 | 1 = line fill, 0 = single word read |
| req_addr | input | ADDR_W | Byte address of the requested (critical) word |
| mode_fast | input | 1 | 1 = pipelined handshake, 0 = registered handshake |
| req_ready | output | 1 | Idle, so a request is accepted this clock |
| rsp_valid | output | 1 | A word is returned this clock |
| rsp_data | output | DATA_W | Returned word |
| rsp_offset | output | log2(LINE_WORDS) | Slot of the returned word within the line |
| rsp_done | output | 1 | Last word of the request |
| cyc_o | output | 1 | Bus cycle in progress |
| stb_o | output | 1 | Bus strobe |
| we_o | output | 1 | Write enable, always low |
| adr_o | output | ADDR_W | Bus byte address |
| ack_i | input | 1 | Memory acknowledge |
| dat_i | input | DATA_W | Memory read data |

## Verification
The bound checker watches the bus shape on every clock. It checks that the strobe never appears outside a cycle and that the cycle is held until the last acknowledge and dropped after it. It checks that the address advances modulo the line while its upper bits stay fixed, and that the address is stable across wait clocks. It also checks the per-mode strobe behaviour after an acknowledge: held in pipelined mode, dropped in registered mode.

Only the bench's scenarios can show the rest: the exact clock each beat lands in for both modes with and without a first-beat wait, the wrap order from a mid-line critical word, the data and slot offsets returned, the idle clock and the ready timing after a transaction, and that requests and mode changes made while the block is busy are ignored.

// File: rtl/lfb_pkg.sv
package lfb_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BUS  = 2'd1,
      ST_GAP  = 2'd2,
      ST_REST = 2'd3
   } lfb_state_e;
endpackage

// File: rtl/lfb_addr_seq.sv
module lfb_addr_seq #(
   parameter int ADDR_W     = 32,
   parameter int LINE_WORDS = 4,
   parameter int BYTE_W     = 2,
   localparam int OFF_W     = $clog2(LINE_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              load_line,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              step,
   output logic [ADDR_W-1:0] adr,
   output logic [OFF_W-1:0]  offset,
   output logic              last
);
   localparam int LO = OFF_W + BYTE_W;

   logic [ADDR_W-1:LO] base_q;
   logic [OFF_W-1:0]   off_q;
   logic [OFF_W-1:0]   beat_q;
   logic               line_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         off_q  <= '0;
         beat_q <= '0;
         line_q <= 1'b0;
      end else if (load) begin
         base_q <= load_addr[ADDR_W-1:LO];
         off_q  <= load_addr[LO-1:BYTE_W];
         beat_q <= '0;
         line_q <= load_line;
      end else if (step) begin
         off_q  <= off_q + 1'b1;   // natural wrap inside the aligned line
         beat_q <= beat_q + 1'b1;
      end
   end

   assign offset = off_q;
   assign last   = line_q ? (beat_q == OFF_W'(LINE_WORDS - 1)) : 1'b1;

   generate
      if (BYTE_W > 0) begin : g_byte_lanes
         logic unused_byte_bits;
         assign unused_byte_bits = ^load_addr[BYTE_W-1:0];
         assign adr = {base_q, off_q, {BYTE_W{1'b0}}};
      end else begin : g_word_addr
         assign adr = {base_q, off_q};
      end
   endgenerate
endmodule

// File: rtl/lfb_ctrl.sv
module lfb_ctrl
   import lfb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic mode_fast,
   input  logic ack,
   input  logic last,
   output logic req_ready,
   output logic load,
   output logic cyc,
   output logic stb,
   output logic beat
);
   lfb_state_e state_q, state_d;
   logic       fast_q;

   assign req_ready = (state_q == ST_IDLE);
   assign load      = req_ready && req_valid;
   assign stb       = (state_q == ST_BUS);
   assign cyc       = stb || (state_q == ST_GAP);
   assign beat      = stb && ack;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (req_valid) state_d = ST_BUS;
         ST_BUS: begin
            if (ack) begin
               if (last)        state_d = fast_q ? ST_IDLE : ST_REST;
               else if (!fast_q) state_d = ST_GAP;
            end
         end
         ST_GAP:  state_d = ST_BUS;
         ST_REST: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         fast_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (load) fast_q <= mode_fast;
      end
   end
endmodule

// File: rtl/line_fill_biu.sv
module line_fill_biu #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LINE_WORDS = 4,
   localparam int OFF_W     = $clog2(LINE_WORDS),
   localparam int BYTE_W    = $clog2(DATA_W / 8)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_line,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              mode_fast,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic [OFF_W-1:0]  rsp_offset,
   output logic              rsp_done,
   output logic              cyc_o,
   output logic              stb_o,
   output logic              we_o,
   output logic [ADDR_W-1:0] adr_o,
   input  logic              ack_i,
   input  logic [DATA_W-1:0] dat_i
);
   generate
      if (LINE_WORDS < 2 || (1 << OFF_W) != LINE_WORDS) begin : g_bad_line
         $error("LINE_WORDS must be a power of two, at least 2");
      end
      if (DATA_W < 8 || (8 << BYTE_W) != DATA_W) begin : g_bad_data
         $error("DATA_W must be 8 times a power of two");
      end
      if (ADDR_W <= OFF_W + BYTE_W) begin : g_bad_addr
         $error("ADDR_W too small for the line");
      end
   endgenerate

   logic load, beat, last;

   lfb_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .mode_fast (mode_fast),
      .ack       (ack_i),
      .last      (last),
      .req_ready (req_ready),
      .load      (load),
      .cyc       (cyc_o),
      .stb       (stb_o),
      .beat      (beat)
   );

   lfb_addr_seq #(
      .ADDR_W     (ADDR_W),
      .LINE_WORDS (LINE_WORDS),
      .BYTE_W     (BYTE_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_line (req_line),
      .load_addr (req_addr),
      .step      (beat),
      .adr       (adr_o),
      .offset    (rsp_offset),
      .last      (last)
   );

   assign rsp_valid = beat;
   assign rsp_data  = dat_i;
   assign rsp_done  = beat && last;
   assign we_o      = 1'b0;
endmodule

// File: rtl/lfb_checker.sv
module lfb_checker #(
   parameter int ADDR_W     = 32,
   parameter int LINE_WORDS = 4,
   parameter int BYTE_W     = 2,
   localparam int OFF_W     = $clog2(LINE_WORDS),
   localparam int LO        = OFF_W + BYTE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              mode_fast,
   input logic              req_ready,
   input logic              rsp_done,
   input logic              cyc_o,
   input logic              stb_o,
   input logic [ADDR_W-1:0] adr_o,
   input logic              ack_i
);
   logic chk_fast;
   always_ff @(posedge clk) begin
      if (!rst_n)                       chk_fast <= 1'b0;
      else if (req_valid && req_ready)  chk_fast <= mode_fast;
   end

   a_r6_stb_in_cyc: assert property (@(posedge clk) disable iff (!rst_n)
      stb_o |-> cyc_o);
   a_r6_cyc_held: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_o && !rsp_done) |=> cyc_o);
   a_r6_cyc_drop: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !cyc_o);
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !cyc_o);
   a_r4_strobe_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_o && ack_i && !rsp_done && chk_fast) |=> stb_o);
   a_r5_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_o && ack_i && !chk_fast) |=> !stb_o);
   a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_o && ack_i && !rsp_done) |=>
         (adr_o[ADDR_W-1:LO] == $past(adr_o[ADDR_W-1:LO])) &&
         (adr_o[LO-1:BYTE_W] == OFF_W'($past(adr_o[LO-1:BYTE_W]) + 1'b1)));
   a_r10_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_o && !ack_i) |=> (stb_o && $stable(adr_o)));
endmodule

bind line_fill_biu lfb_checker #(
   .ADDR_W     (ADDR_W),
   .LINE_WORDS (LINE_WORDS),
   .BYTE_W     (BYTE_W)
) u_lfb_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .mode_fast (mode_fast),
   .req_ready (req_ready),
   .rsp_done  (rsp_done),
   .cyc_o     (cyc_o),
   .stb_o     (stb_o),
   .adr_o     (adr_o),
   .ack_i     (ack_i)
);

// File: tb/test_line_fill_biu.sv
`timescale 1ns/1ps
module test_line_fill_biu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_line = 1'b0, mode_fast = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_ready, rsp_valid, rsp_done, cyc_o, stb_o, we_o, ack_i;
   logic [31:0] rsp_data, adr_o, dat_i;
   logic [1:0]  rsp_offset;

   int n_checks = 0;
   int n_fails  = 0;

   always #2 clk = ~clk;

   line_fill_biu i_line_fill_biu (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line(req_line),
      .req_addr(req_addr), .mode_fast(mode_fast), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_offset(rsp_offset),
      .rsp_done(rsp_done), .cyc_o(cyc_o), .stb_o(stb_o), .we_o(we_o),
      .adr_o(adr_o), .ack_i(ack_i), .dat_i(dat_i)
   );

   // memory model: first beat of a cycle waits first_wait clocks, later beats ack at once
   logic [1:0] first_wait = 2'd0;
   logic [1:0] stall_cnt;
   logic       seen;
   always_ff @(posedge clk) begin
      if (!cyc_o) begin
         seen <= 1'b0; stall_cnt <= 2'd0;
      end else if (stb_o && ack_i) seen <= 1'b1;
      else if (stb_o) stall_cnt <= stall_cnt + 2'd1;
   end
   assign ack_i = stb_o && (seen || stall_cnt >= first_wait);
   assign dat_i = {~adr_o[15:0], adr_o[15:0]};

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return {~a[15:0], a[15:0]};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one transaction, checked clock by clock; clock 0 is the accepting clock
   task automatic run_txn(input bit line, input bit fast, input logic [31:0] addr,
                          input logic [1:0] w, input bit disturb);
      int nbeats = line ? 4 : 1;
      int nb = 0;
      int kdone = -1;
      logic [31:0] prev_adr = '0;
      @(negedge clk);
      first_wait = w;
      req_valid = 1'b1; req_line = line; mode_fast = fast; req_addr = addr;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 1; k <= 14; k++) begin
         if (kdone < 0) begin
            if (k <= int'(w)) begin
               chk(stb_o && !ack_i, "R10 strobe held while waiting", {31'd0, stb_o}, 32'd1);
               if (k > 1) chk(adr_o == prev_adr, "R10 address steady", adr_o, prev_adr);
            end else begin
               chk(cyc_o, "R6 cyc held in transaction", {31'd0, cyc_o}, 32'd1);
            end
         end
         if (rsp_valid) begin
            logic [31:0] exp_adr;
            logic [1:0]  exp_off;
            int exp_k;
            exp_off = line ? 2'(addr[3:2] + 2'(nb)) : addr[3:2];
            exp_adr = {addr[31:4], exp_off, 2'b00};
            exp_k = (fast ? nb + 1 : 2 * nb + 1) + int'(w);
            chk(k == exp_k, fast ? "R4 beat clock" : "R5 beat clock", k, exp_k);
            chk(adr_o == exp_adr, line ? "R3 wrap address" : "R7 single address", adr_o, exp_adr);
            chk(rsp_offset == exp_off, "R3 slot offset", {30'd0, rsp_offset}, {30'd0, exp_off});
            chk(rsp_data == mem_word(exp_adr), "R2 word data", rsp_data, mem_word(exp_adr));
            chk(rsp_done == (nb == nbeats - 1), line ? "R2 done on last" : "R7 done on single",
                {31'd0, rsp_done}, {31'd0, nb == nbeats - 1});
            if (rsp_done) kdone = k;
            nb++;
         end else if (kdone < 0 && k > int'(w) && !fast) begin
            chk(!stb_o, "R5 strobe gap", {31'd0, stb_o}, 32'd0);
         end
         if (kdone > 0 && k == kdone + 1) begin
            if (fast) chk(req_ready && !cyc_o, "R7 ready after last", {30'd0, req_ready, cyc_o}, 32'd2);
            else chk(!req_ready && !cyc_o, "R8 idle clock", {30'd0, req_ready, cyc_o}, 32'd0);
         end
         if (!fast && kdone > 0 && k == kdone + 2)
            chk(req_ready, "R8 ready after idle", {31'd0, req_ready}, 32'd1);
         if (kdone > 0 && k >= kdone + 3)
            chk(!cyc_o, "R9 no second transaction", {31'd0, cyc_o}, 32'd0);
         chk(!we_o, "R11 read only", {31'd0, we_o}, 32'd0);
         prev_adr = adr_o;
         if (disturb && k == 1) begin
            req_valid = 1'b1; mode_fast = ~fast; req_line = ~line; req_addr = 32'h0000_0F04;
         end
         if (k == 2) req_valid = 1'b0;
         @(negedge clk);
      end
      chk(nb == nbeats, line ? "R2 beat count" : "R7 beat count", nb, nbeats);
   endtask

   task automatic t_reset();
      chk(!cyc_o && !stb_o && !rsp_valid && !rsp_done && req_ready, "R1 reset state",
          {27'd0, cyc_o, stb_o, rsp_valid, rsp_done, req_ready}, 32'd1);
   endtask
   task automatic t_fast_fill();     run_txn(1'b1, 1'b1, 32'h1000_0040, 2'd0, 1'b0); endtask // R4
   task automatic t_fast_fill_wait(); run_txn(1'b1, 1'b1, 32'h2000_0128, 2'd1, 1'b0); endtask // R3 R10
   task automatic t_slow_fill();     run_txn(1'b1, 1'b0, 32'h3000_00BC, 2'd0, 1'b0); endtask // R5 R8
   task automatic t_slow_fill_wait(); run_txn(1'b1, 1'b0, 32'h3000_0204, 2'd2, 1'b0); endtask // R5 R10
   task automatic t_fast_single();   run_txn(1'b0, 1'b1, 32'h4000_0018, 2'd0, 1'b0); endtask // R7
   task automatic t_slow_single();   run_txn(1'b0, 1'b0, 32'h5000_0014, 2'd1, 1'b0); endtask // R8
   task automatic t_busy_ignore();   run_txn(1'b1, 1'b1, 32'h6000_0304, 2'd0, 1'b1); endtask // R9
   task automatic t_busy_ignore_s(); run_txn(1'b0, 1'b0, 32'h7000_000C, 2'd0, 1'b1); endtask // R9

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fast_fill();
      t_fast_fill_wait();
      t_slow_fill();
      t_slow_fill_wait();
      t_fast_single();
      t_slow_single();
      t_busy_ignore();
      t_busy_ignore_s();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end
endmodule